// File: doc/BRIEF.md
# Rolling Pixel Row Control Sequencer

This block drives the three control lines of every row of an active-pixel image array: an active-low reset, an active-low shutter and an active-high row select. One start pulse launches a frame over a window of consecutive rows. Every row in the window goes through the same four phases in order: reset, exposure, hold and readout. Each row starts one readout slot after the row before it. The readouts therefore form an unbroken chain of non-overlapping slots on the shared column lines.

The exposure length and the slot length are cycle counts. They are captured together with the window bounds on the start pulse, so changes on these inputs during a frame have no effect. The block signals the end of a frame with a one-cycle flag and then returns to idle.

Timing is stated in the cycles after start. Cycle t=0 is the first cycle after the rising clock edge that samples an accepted start. N is the number of window rows, E is the captured exposure count, and L is the captured slot count. The row at position k inside the window (k=0 for the first window row) has base b = k*L.

Top module: `rolling_row_sequencer`

## Requirements
- R1: After reset, every reset_n and shutter_n bit is high, row_sel is all zero and frame_done is low.
- R2: The window row at position k drives reset_n and shutter_n low together in cycle b only. A reset_n bit is never low while its shutter_n bit is high.
- R3: In cycles b+1 through b+E, that row holds reset_n high and shutter_n low (exposure). With E=0 there is no exposure cycle.
- R4: In cycle b+E+1, that row has shutter_n high and its row_sel bit low (hold). shutter_n stays high from then until the end of the frame.
- R5: That row's row_sel bit is high in cycles b+E+2 through b+E+1+L and low at all other times. A row_sel bit is never high while the same row's shutter_n is low.
- R6: At most one row_sel bit is high in any cycle. Select passes from one window row to the next with no gap cycle.
- R7: Rows below first_row or above last_row keep reset_n and shutter_n high and row_sel low for the whole frame.
- R8: frame_done is high in cycle N*L+E+2 only. In that cycle and afterwards, all row outputs are idle, and a new start is accepted from that cycle on.
- R9: A readout length of 0 is treated as a slot of 1 cycle.
- R10: A start is ignored while a frame is in progress. A start is also ignored when first_row > last_row or last_row >= NUM_ROWS.
- R11: Window bounds and both cycle counts are captured on the accepted start. Changes to these inputs during a frame leave that frame's timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame launch request |
| first_row | input | $clog2(NUM_ROWS) | Lowest row of the window |
| last_row | input | $clog2(NUM_ROWS) | Highest row of the window |
| expo_cycles | input | CNT_W | Exposure length E in cycles |
| read_cycles | input | CNT_W | Readout slot length L in cycles (0 means 1) |
| reset_n | output | NUM_ROWS | Per-row pixel reset, active low |
| shutter_n | output | NUM_ROWS | Per-row shutter, active low (low = integrating) |
| row_sel | output | NUM_ROWS | Per-row readout select, active high |
| frame_done | output | 1 | One-cycle end-of-frame flag |

## Verification
The reset of one window row and the shutter close of an earlier row can fall in the same cycle. This happens whenever E+1 is a multiple of L. The shutter close of that earlier row also coincides with the select handover between two rows. Directed frames with E=3, L=2 and with E=0, L=1 force these collisions, and random frames hit them often. In every cycle, the bench compares all three per-row vectors and frame_done with a cycle-exact model. The hand-over rows must show exactly the reset, hold and select values the timing rules give, with no missing or extra select cycle.

// File: rtl/rolling_row_sequencer.sv
module rolling_row_sequencer #(
  parameter int NUM_ROWS = 8,
  parameter int CNT_W    = 12,
  localparam int RW      = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [RW-1:0]       first_row,
  input  logic [RW-1:0]       last_row,
  input  logic [CNT_W-1:0]    expo_cycles,
  input  logic [CNT_W-1:0]    read_cycles,
  output logic [NUM_ROWS-1:0] reset_n,
  output logic [NUM_ROWS-1:0] shutter_n,
  output logic [NUM_ROWS-1:0] row_sel,
  output logic                frame_done
);
  localparam int KW = $clog2(NUM_ROWS + 1);

  logic                busy, trail_run, done_q;
  logic [RW-1:0]       first_q;
  logic [KW-1:0]       nrows_q, k_a, k_b;
  logic [CNT_W-1:0]    expo_q, slot_q, s_a, s_b, w;
  logic [NUM_ROWS-1:0] open_q, sel_q, rst_now, close_now;
  logic [KW:0]         lead_row, trail_row;

  wire win_ok    = (first_row <= last_row) && (int'(last_row) < NUM_ROWS);
  wire launch    = start && !busy && win_ok;
  wire lead_hit  = busy && (s_a == '0) && (k_a < nrows_q);
  wire close_hit = trail_run && (s_b == '0) && (k_b < nrows_q);
  wire done_evt  = trail_run && (s_b == '0) && (k_b == nrows_q);

  assign lead_row  = (KW+1)'(first_q) + (KW+1)'(k_a);
  assign trail_row = (KW+1)'(first_q) + (KW+1)'(k_b);

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
    assign rst_now[i]   = lead_hit  && (lead_row  == (KW+1)'(i));
    assign close_now[i] = close_hit && (trail_row == (KW+1)'(i));
  end

  assign reset_n    = ~rst_now;
  assign shutter_n  = ~(rst_now | (open_q & ~close_now));
  assign row_sel    = sel_q;
  assign frame_done = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; trail_run <= 1'b0; done_q <= 1'b0;
      first_q <= '0; nrows_q <= '0; expo_q <= '0; slot_q <= '0;
      s_a <= '0; k_a <= '0; s_b <= '0; k_b <= '0; w <= '0;
      open_q <= '0; sel_q <= '0;
    end else begin
      done_q <= done_evt;
      if (launch) begin
        busy      <= 1'b1;
        trail_run <= 1'b0;
        first_q   <= first_row;
        nrows_q   <= KW'(last_row) - KW'(first_row) + KW'(1);
        expo_q    <= expo_cycles;
        slot_q    <= (read_cycles == '0) ? CNT_W'(1) : read_cycles;
        s_a <= '0; k_a <= '0; s_b <= '0; k_b <= '0; w <= '0;
        open_q <= '0; sel_q <= '0;
      end else if (busy) begin
        if (k_a < nrows_q) begin
          if (s_a == slot_q - CNT_W'(1)) begin
            s_a <= '0;
            k_a <= k_a + KW'(1);
          end else s_a <= s_a + CNT_W'(1);
        end
        if (!trail_run) begin
          if (w == expo_q) trail_run <= 1'b1;
          else w <= w + CNT_W'(1);
        end else if (s_b == slot_q - CNT_W'(1)) begin
          s_b <= '0;
          k_b <= k_b + KW'(1);
        end else s_b <= s_b + CNT_W'(1);
        open_q <= (open_q | rst_now) & ~close_now;
        if (close_hit) sel_q <= close_now;
        if (done_evt) begin
          sel_q     <= '0;
          busy      <= 1'b0;
          trail_run <= 1'b0;
        end
      end
    end
  end

  p_one_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_sel));
  p_reset_with_shutter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((~reset_n) & shutter_n) == '0);
  p_sel_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (row_sel & ~shutter_n) == '0);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (row_sel == '0) && (&shutter_n) && (&reset_n));
endmodule

// File: tb/rolling_row_sequencer_tb.sv
module rolling_row_sequencer_tb;
  localparam int NR = 8;
  localparam int CW = 12;
  localparam int RW = $clog2(NR);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [RW-1:0] first_row = '0, last_row = '0;
  logic [CW-1:0] expo_cycles = '0, read_cycles = '0;
  logic [NR-1:0] reset_n, shutter_n, row_sel;
  logic frame_done;
  int checks = 0, errors = 0;

  rolling_row_sequencer #(.NUM_ROWS(NR), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .first_row(first_row),
    .last_row(last_row), .expo_cycles(expo_cycles), .read_cycles(read_cycles),
    .reset_n(reset_n), .shutter_n(shutter_n), .row_sel(row_sel),
    .frame_done(frame_done));

  always #5 clk = ~clk;

  // returns {reset_n, shutter_n, row_sel} for row i at cycle t
  function automatic logic [2:0] exp_row(int i, int f, int n, int e, int l, int t);
    int b;
    if (i < f || i > f + n - 1) return 3'b110;
    b = (i - f) * l;
    if (t == b) return 3'b000;
    if (t > b && t <= b + e) return 3'b100;
    if (t >= b + e + 2 && t <= b + e + 1 + l) return 3'b111;
    return 3'b110;
  endfunction

  task automatic chk(logic ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare(int f, int n, int e, int l, int t);
    logic [NR-1:0] er, es, el;
    logic [2:0] v;
    logic out_ok;
    for (int i = 0; i < NR; i++) begin
      v = exp_row(i, f, n, e, l, t);
      er[i] = v[2]; es[i] = v[1]; el[i] = v[0];
    end
    chk(reset_n == er, "R2 reset_n", 32'(reset_n), 32'(er));
    chk(shutter_n == es, "R3/R4 shutter_n", 32'(shutter_n), 32'(es));
    chk(row_sel == el, "R5 row_sel", 32'(row_sel), 32'(el));
    chk(frame_done == (t == n * l + e + 2), "R8 frame_done",
        32'(frame_done), 32'(t == n * l + e + 2));
    chk($countones(row_sel) <= 1, "R6 single select", 32'(row_sel), 32'(0));
    out_ok = 1'b1;
    for (int i = 0; i < NR; i++)
      if ((i < f || i >= f + n) && !(reset_n[i] && shutter_n[i] && !row_sel[i]))
        out_ok = 1'b0;
    chk(out_ok, "R7 outside window idle", 32'(row_sel), 32'(el));
  endtask

  task automatic run_frame(int f, int la, int e, int r, bit disturb);
    int l, n, tend;
    l = (r == 0) ? 1 : r;
    n = la - f + 1;
    tend = n * l + e + 2;
    first_row = RW'(f); last_row = RW'(la);
    expo_cycles = CW'(e); read_cycles = CW'(r);
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    for (int t = 0; t <= tend + 1; t++) begin
      compare(f, n, e, l, t);
      if (disturb && t == 1) begin // R10 R11
        start = 1'b1;
        first_row = RW'($urandom_range(0, NR - 1)); last_row = RW'(NR - 1);
        expo_cycles = CW'($urandom_range(0, 9)); read_cycles = CW'($urandom_range(0, 5));
      end
      if (disturb && t == 2) start = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(reset_n == '1 && shutter_n == '1, "R1 reset pixel lines",
        32'({reset_n, shutter_n}), 32'(16'hffff));
    chk(row_sel == '0 && !frame_done, "R1 select and done idle",
        32'({row_sel, frame_done}), 32'(0));
    rst_n = 1'b1;
    @(negedge clk);
    run_frame(0, 7, 3, 2, 1'b0);        // R2 R3 R4 R5 R6: reset coincides with close
    run_frame(5, 5, 4, 3, 1'b0);        // R7 single row
    run_frame(2, 4, 0, 1, 1'b0);        // R3 zero exposure, R6 back-to-back
    run_frame(1, 3, 2, 0, 1'b0);        // R9 zero readout length
    run_frame(0, 6, 5, 3, 1'b1);        // R10 R11 disturbed mid-frame
    // R10 invalid window is ignored
    first_row = RW'(6); last_row = RW'(2); start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 4; t++) begin
      chk(reset_n == '1 && shutter_n == '1 && row_sel == '0 && !frame_done,
          "R10 invalid window ignored", 32'({reset_n, row_sel}), 32'(16'hff00));
      @(negedge clk);
    end
    for (int k = 0; k < 25; k++) begin
      int f, la;
      f  = $urandom_range(0, NR - 1);
      la = $urandom_range(f, NR - 1);
      run_frame(f, la, $urandom_range(0, 12), $urandom_range(0, 5), k % 4 == 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule